// File: doc/BRIEF.md
# Run/Pause Sequence Counter with Decimal Display

This block runs a 4-bit sequence counter from three momentary pushbuttons and a direction switch, and shows the count on two seven-segment displays. The count does not run in binary order. Going up, it visits 1, 2, 4, 8, 3, 6, 12, 11, 5, 10, 7, 14, 15, 13, 9 and then wraps to 1. Going down, it visits the same values in reverse.

One button puts the block into a running mode and another puts it into a paused mode. The mode stays in place after the button is released. A clock divider makes a one-cycle tick once every `DIV_COUNT` input clocks, which is one second at 50 MHz. The counter steps only on a tick while the mode is running. The third button is a clear that the block samples synchronously. While it is held, the divider returns to zero, the mode goes to paused, and the counter loads its starting value for the present direction. The count appears as two decimal digits with active-low segments.

The block holds two state machines. The mode machine has the states PAUSED and RUNNING. Its transitions are GO (PAUSED to RUNNING, start pressed and stop not pressed), HALT (RUNNING to PAUSED, stop pressed) and CLEAR (any state to PAUSED). The sequence machine has fifteen states, SQ_01 to SQ_15, each named after the value it outputs. Its transitions are STEP_UP and STEP_DOWN to the neighbouring value, taken when an advance occurs, and CLEAR, which goes to SQ_01 when the direction is up and to SQ_09 when it is down.

Top module: `rps_counter_display`

## Requirements
- R1: At a clock edge where the clear button reads low, the count loads 1 if `dir_up` is 1 and 9 if `dir_up` is 0, and the mode becomes paused.
- R2: After a clear, the count does not change until the start button has been pressed.
- R3: A start press (low) with stop released (high) sets running mode at the next edge, and running mode persists after release while both buttons are high.
- R4: A stop press sets paused mode at the next edge, even when start is pressed in the same cycle, and the count then stays frozen.
- R5: The count advances only on an edge where the mode is running and the divider's last count is reached. The divider reaches its last count once every `DIV_COUNT` clocks, the first time `DIV_COUNT` clocks after the clear is released.
- R6: With `dir_up` = 1, each advance moves the count to the next value in 1, 2, 4, 8, 3, 6, 12, 11, 5, 10, 7, 14, 15, 13, 9, and from 9 it wraps to 1.
- R7: With `dir_up` = 0, each advance moves the count to the previous value in that list, and from 1 it wraps to 9.
- R8: A change of `dir_up` while running takes effect at the next advance, starting from the current value.
- R9: `seg_ones` shows the count modulo 10. Bit 0 is segment a and bit 6 is segment g, and a lit segment is 0. Digits 0 to 9 use the active-high patterns 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F (hex), inverted.
- R10: `seg_tens` shows the digit 1 (pattern ~06) for counts 10 to 15 and the digit 0 (pattern ~3F) for other counts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock (50 MHz on the board) |
| btn_go_n | input | 1 | Start/resume button, low while pressed |
| btn_halt_n | input | 1 | Stop/pause button, low while pressed |
| btn_clr_n | input | 1 | Clear button, low while pressed, sampled on the clock |
| dir_up | input | 1 | Direction switch: 1 counts up, 0 counts down |
| seg_ones | output | 7 | Ones digit segments, active-low, bit 0 = a |
| seg_tens | output | 7 | Tens digit segments, active-low, bit 0 = a |

## Verification
The assertions assume that the buttons arrive already debounced and synchronous to `clk`, and that each press covers whole clock cycles. Because the clear button is sampled on the clock, every clocked property is disabled while it reads low. The properties also assume that the direction switch changes only between edges. The bench drives every button and the switch 2 ns after a rising edge and holds each value for whole cycles, so the inputs always meet these assumptions.

// File: rtl/rps_pkg.sv
package rps_pkg;
    localparam int CNT_W      = 4;
    localparam int SEG_W      = 7;
    localparam int NUM_DIGITS = 2;
    localparam int RADIX      = 10;

    typedef logic [SEG_W-1:0] seg_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic {
        MODE_PAUSED  = 1'b0,
        MODE_RUNNING = 1'b1
    } run_mode_e;

    typedef enum logic [CNT_W-1:0] {
        SQ_01 = 4'd1,  SQ_02 = 4'd2,  SQ_03 = 4'd3,  SQ_04 = 4'd4,
        SQ_05 = 4'd5,  SQ_06 = 4'd6,  SQ_07 = 4'd7,  SQ_08 = 4'd8,
        SQ_09 = 4'd9,  SQ_10 = 4'd10, SQ_11 = 4'd11, SQ_12 = 4'd12,
        SQ_13 = 4'd13, SQ_14 = 4'd14, SQ_15 = 4'd15
    } seq_state_e;
endpackage

// File: rtl/rps_tick_gen.sv
module rps_tick_gen #(
    parameter int unsigned DIV_COUNT = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned DIV_W = (DIV_COUNT > 1) ? $clog2(DIV_COUNT) : 1;
    localparam logic [DIV_W-1:0] LAST = DIV_W'(DIV_COUNT - 1);

    logic [DIV_W-1:0] div_q;

    always_ff @(posedge clk) begin
        if (!rst_n)            div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                   div_q <= div_q + DIV_W'(1);
    end

    always_comb tick = (div_q == LAST);

    generate
        if (DIV_COUNT > 1) begin : g_tick_chk
            // R5
            tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/rps_mode_fsm.sv
module rps_mode_fsm
    import rps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic go_n,
    input  logic halt_n,
    output logic running
);
    run_mode_e mode_q, mode_d;

    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= MODE_PAUSED;
        else        mode_q <= mode_d;
    end

    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            MODE_PAUSED: begin
                if (!halt_n)   mode_d = MODE_PAUSED;
                else if (!go_n) mode_d = MODE_RUNNING;
            end
            MODE_RUNNING: begin
                if (!halt_n) mode_d = MODE_PAUSED;
            end
            default: mode_d = MODE_PAUSED;
        endcase
    end

    always_comb running = (mode_q == MODE_RUNNING);

    // R4
    halt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !halt_n |=> !running);
    // R3
    go_sets_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_n && !go_n) |=> running);
    // R3
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_n && go_n) |=> $stable(running));
endmodule

// File: rtl/rps_seq_fsm.sv
module rps_seq_fsm
    import rps_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dir_up,
    input  logic advance,
    output cnt_t count
);
    seq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n)       state_q <= dir_up ? SQ_01 : SQ_09;
        else if (advance) state_q <= state_d;
    end

    always_comb begin
        state_d = SQ_01;
        unique case (state_q)
            SQ_01: state_d = dir_up ? SQ_02 : SQ_09;
            SQ_02: state_d = dir_up ? SQ_04 : SQ_01;
            SQ_04: state_d = dir_up ? SQ_08 : SQ_02;
            SQ_08: state_d = dir_up ? SQ_03 : SQ_04;
            SQ_03: state_d = dir_up ? SQ_06 : SQ_08;
            SQ_06: state_d = dir_up ? SQ_12 : SQ_03;
            SQ_12: state_d = dir_up ? SQ_11 : SQ_06;
            SQ_11: state_d = dir_up ? SQ_05 : SQ_12;
            SQ_05: state_d = dir_up ? SQ_10 : SQ_11;
            SQ_10: state_d = dir_up ? SQ_07 : SQ_05;
            SQ_07: state_d = dir_up ? SQ_14 : SQ_10;
            SQ_14: state_d = dir_up ? SQ_15 : SQ_07;
            SQ_15: state_d = dir_up ? SQ_13 : SQ_14;
            SQ_13: state_d = dir_up ? SQ_09 : SQ_15;
            SQ_09: state_d = dir_up ? SQ_01 : SQ_13;
            default: state_d = SQ_01;
        endcase
    end

    always_comb count = cnt_t'(state_q);

    // R5
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(count));
    // R6
    up_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && dir_up && count == 4'd9) |=> count == 4'd1);
    // R7
    down_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !dir_up && count == 4'd1) |=> count == 4'd9);
endmodule

// File: rtl/rps_seg_decoder.sv
module rps_seg_decoder
    import rps_pkg::*;
#(
    parameter bit ACTIVE_LOW = 1'b1
) (
    input  cnt_t digit,
    output seg_t seg
);
    seg_t lit;

    always_comb begin
        unique case (digit)
            4'd0:    lit = 7'h3F;
            4'd1:    lit = 7'h06;
            4'd2:    lit = 7'h5B;
            4'd3:    lit = 7'h4F;
            4'd4:    lit = 7'h66;
            4'd5:    lit = 7'h6D;
            4'd6:    lit = 7'h7D;
            4'd7:    lit = 7'h07;
            4'd8:    lit = 7'h7F;
            4'd9:    lit = 7'h6F;
            default: lit = 7'h00;
        endcase
    end

    generate
        if (ACTIVE_LOW) begin : g_low
            always_comb seg = ~lit;
        end else begin : g_high
            always_comb seg = lit;
        end
    endgenerate
endmodule

// File: rtl/rps_counter_display.sv
module rps_counter_display
    import rps_pkg::*;
#(
    parameter int unsigned DIV_COUNT = 50_000_000
) (
    input  logic       clk,
    input  logic       btn_go_n,
    input  logic       btn_halt_n,
    input  logic       btn_clr_n,
    input  logic       dir_up,
    output logic [6:0] seg_ones,
    output logic [6:0] seg_tens
);
    localparam cnt_t TEN = cnt_t'(RADIX);

    logic tick;
    logic running;
    logic advance;
    cnt_t count;
    cnt_t digit_val [NUM_DIGITS];
    seg_t seg_bus   [NUM_DIGITS];

    rps_tick_gen #(.DIV_COUNT(DIV_COUNT)) u_tick (
        .clk   (clk),
        .rst_n (btn_clr_n),
        .tick  (tick)
    );

    rps_mode_fsm u_mode (
        .clk     (clk),
        .rst_n   (btn_clr_n),
        .go_n    (btn_go_n),
        .halt_n  (btn_halt_n),
        .running (running)
    );

    always_comb advance = running & tick;

    rps_seq_fsm u_seq (
        .clk     (clk),
        .rst_n   (btn_clr_n),
        .dir_up  (dir_up),
        .advance (advance),
        .count   (count)
    );

    always_comb begin
        digit_val[0] = (count >= TEN) ? (count - TEN) : count;
        digit_val[1] = (count >= TEN) ? cnt_t'(1) : cnt_t'(0);
    end

    generate
        for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
            rps_seg_decoder #(.ACTIVE_LOW(1'b1)) u_dec (
                .digit (digit_val[g]),
                .seg   (seg_bus[g])
            );
        end
    endgenerate

    always_comb begin
        seg_ones = seg_bus[0];
        seg_tens = seg_bus[1];
    end

    // R10
    tens_pattern_chk: assert property (@(posedge clk) disable iff (!btn_clr_n)
        (seg_tens == ~7'h06) || (seg_tens == ~7'h3F));
    // R4
    paused_frozen_chk: assert property (@(posedge clk) disable iff (!btn_clr_n)
        (!btn_halt_n) |=> ##1 $stable(seg_ones));
endmodule

// File: tb/rps_counter_display_bench.sv
`timescale 1ns/1ps
module rps_counter_display_bench;
    localparam int DIV = 6;
    localparam int SEQ_N = 15;

    logic clk = 1'b0;
    logic btn_go_n = 1'b1, btn_halt_n = 1'b1, btn_clr_n = 1'b0, dir_up = 1'b1;
    logic [6:0] seg_ones, seg_tens;

    int checks = 0, fails = 0;
    bit done = 1'b0;
    string tag = "R1";

    int seq [$] = '{1, 2, 4, 8, 3, 6, 12, 11, 5, 10, 7, 14, 15, 13, 9};
    int m_div = 0, m_idx = 0;
    bit m_run = 1'b0, model_ok = 1'b0;

    always #4 clk = ~clk;

    rps_counter_display #(.DIV_COUNT(DIV)) u_rps_counter_display (
        .clk(clk), .btn_go_n(btn_go_n), .btn_halt_n(btn_halt_n),
        .btn_clr_n(btn_clr_n), .dir_up(dir_up),
        .seg_ones(seg_ones), .seg_tens(seg_tens)
    );

    function automatic logic [6:0] enc(int d);
        logic [6:0] p;
        case (d)
            0: p = 7'h3F; 1: p = 7'h06; 2: p = 7'h5B; 3: p = 7'h4F; 4: p = 7'h66;
            5: p = 7'h6D; 6: p = 7'h7D; 7: p = 7'h07; 8: p = 7'h7F; default: p = 7'h6F;
        endcase
        return ~p;
    endfunction

    task automatic chk(string t, logic [6:0] act, logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s at %0t: actual %h expected %h", t, $time, act, exp);
        end
    endtask

    task automatic chk_value(string t, int v);
        chk({t, " R9 ones"}, seg_ones, enc(v % 10));
        chk({t, " R10 tens"}, seg_tens, enc(v / 10));
    endtask

    // Behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        if (!btn_clr_n) begin
            m_div = 0; m_run = 1'b0; m_idx = dir_up ? 0 : SEQ_N - 1; model_ok = 1'b1;
        end else if (model_ok) begin
            if (m_run && m_div == DIV - 1)
                m_idx = dir_up ? (m_idx + 1) % SEQ_N : (m_idx + SEQ_N - 1) % SEQ_N;
            m_div = (m_div == DIV - 1) ? 0 : m_div + 1;
            if (!btn_halt_n)   m_run = 1'b0;
            else if (!btn_go_n) m_run = 1'b1;
        end
    end

    always @(negedge clk) begin
        if (model_ok && !done) chk_value({tag, " model"}, seq[m_idx]);
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic press_go();
        btn_go_n = 1'b0; cyc(1); btn_go_n = 1'b1;
    endtask

    task automatic press_halt();
        btn_halt_n = 1'b0; cyc(1); btn_halt_n = 1'b1;
    endtask

    initial begin
        cyc(3);
        btn_clr_n = 1'b1;
        @(negedge clk); chk_value("R1 reset up", 1);
        tag = "R2"; cyc(3 * DIV);
        @(negedge clk); chk_value("R2 paused after clear", 1);
        cyc(0);
        tag = "R3"; press_go();
        tag = "R6"; cyc(SEQ_N * DIV + 2);
        tag = "R4"; press_halt(); cyc(1);
        @(negedge clk); begin : frz
            logic [6:0] so, st;
            so = seg_ones; st = seg_tens;
            cyc(3 * DIV);
            @(negedge clk); chk("R4 frozen ones", seg_ones, so);
            chk("R4 frozen tens", seg_tens, st);
        end
        cyc(0);
        btn_go_n = 1'b0; btn_halt_n = 1'b0; cyc(1);
        btn_go_n = 1'b1; btn_halt_n = 1'b1; cyc(3 * DIV);
        tag = "R3"; press_go(); cyc(2 * DIV);
        tag = "R7"; dir_up = 1'b0; cyc(SEQ_N * DIV + 3);
        tag = "R1"; btn_clr_n = 1'b0; cyc(2); btn_clr_n = 1'b1;
        @(negedge clk); chk_value("R1 reset down", 9);
        cyc(0);
        tag = "R5"; press_go(); cyc(4 * DIV + 1);
        tag = "R8"; dir_up = 1'b1; cyc(5 * DIV);
        dir_up = 1'b0; cyc(3 * DIV);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog R5: actual still running, expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule